// File: doc/BRIEF.md
# Error-Correcting Memory Port with Column Sparing

This block sits between a processor's data port and a word-wide memory array. Every word that is written is expanded into an extended Hamming codeword. The code corrects any one flipped bit and detects any two flipped bits. On a read, the block rebuilds the codeword from the stored word, corrects or flags it, and hands back the data one clock later. It also reports the kind of error it saw and the syndrome.

Each stored word also has two spare bit columns. A small configuration port loads up to two steering entries. Each entry names one codeword column that is known to be bad, for example a stuck bit line. From then on, every write copies that codeword bit into the entry's spare column as well. Every read takes the bit from the spare column and ignores the bad one. The replacement applies to every address and stays in force until the entry is rewritten.

Steering sits below the error code. A bad column that has been steered therefore costs no correction capacity, and the code still covers one further random fault.

Top module: `spare_steer_ecc`

## Requirements
- R1: On a cycle with `wr_en` high, `mem_we` is high and `mem_addr` equals `addr` in the same cycle. Bits [CW-1:0] of `mem_wdata` hold the codeword, with CW = data width + check count + 1 (22 for 16 data bits, which gives 5 Hamming check bits). The bit at each power-of-two position 2^i is chosen so that all codeword positions with bit i set have even parity. The data bits fill the remaining non-zero positions in ascending order, starting from the data LSB. Bit 0 makes the whole codeword even parity.
- R2: A cycle with `rd_en` high and `wr_en` low raises `mem_re`. `mem_rdata` is taken in that same cycle. `rd_valid` and all the read results appear registered on the following cycle. When `wr_en` is high, the write wins: there is no `mem_re` and no `rd_valid` for that cycle.
- R3: A read whose rebuilt codeword has no error returns the written data with both flags low and `syndrome` zero.
- R4: A read with exactly one wrong codeword bit at position p returns the corrected data, raises `err_corr` for one cycle and sets `syndrome` to {1, p}. Position 0 gives {1, 0}.
- R5: A read with exactly two wrong codeword bits raises `err_uncorr`. The data bits are returned as read, without correction. `syndrome` is {0, p1 XOR p2}.
- R6: Whenever `rd_valid` is low, both flags are low and `syndrome` is zero. The two flags are never high together. After reset, no read result is valid.
- R7: A cycle with `cfg_we` high loads steering entry `cfg_sel` with enable `cfg_en` and column `cfg_pos`. The new entry governs accesses in that same cycle and in every later cycle until the entry is rewritten. Reset disables both entries.
- R8: On a write, bit CW+k of `mem_wdata` equals the codeword bit at the column of entry k when that entry is effective, and is 0 when it is not. The steered column itself still receives its codeword bit.
- R9: On a read, the stored bit of a steered column is ignored and spare bit CW+k supplies it, at every address. An error in that spare bit is seen as an error at the steered position.
- R10: An entry that names the same column as entry 0 while entry 0 is enabled is not effective. Its spare bit is written as 0 and is ignored on reads.
- R11: An entry whose column is CW or larger is not effective.
- R12: Disabling an entry returns its column to normal use: a fault in the original column is then seen again, and the spare is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request (ignored when wr_en is high) |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Write data |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_data | output | DATA_W | Read data, corrected where possible |
| err_corr | output | 1 | Single-bit error corrected |
| err_uncorr | output | 1 | Double-bit error detected |
| syndrome | output | CHK_W+1 | {parity mismatch, Hamming syndrome} |
| cfg_we | input | 1 | Steering entry write strobe |
| cfg_sel | input | SEL_W | Steering entry index |
| cfg_en | input | 1 | Steering entry enable |
| cfg_pos | input | POS_W | Codeword column to replace |
| mem_we | output | 1 | Array write enable |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | CW+NSP | Stored word: codeword plus spare columns |
| mem_rdata | input | CW+NSP | Stored word read in the same cycle |

## Verification
The bound checker watches the timing and flag rules on every cycle:
- a read request is followed by a valid result one cycle later, and no result appears otherwise;
- reads and writes never overlap;
- both flags and the syndrome stay at zero while no result is valid;
- the flags are exclusive;
- a corrected error carries a set parity bit in the syndrome, and an uncorrectable error a nonzero syndrome.

Several properties depend on which columns were flipped and how steering was set up at the time, so only the bench's scenarios can show them. These are the codeword layout, the value of a corrected word, the raw data passed on a double error, the content of the spare columns, and the masking of a steered column across all addresses. The same applies to the handling of duplicate or out-of-range entries and to the return to normal use once an entry is disabled.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Outcome of decoding one rebuilt codeword
    typedef enum logic [1:0] {
        RD_CLEAN  = 2'd0,
        RD_FIXED  = 2'd1,
        RD_BROKEN = 2'd2
    } rd_kind_e;

    // Smallest Hamming check count r with 2^r >= data + r + 1
    function automatic int chk_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

endpackage

// File: rtl/sbs_hamm_enc.sv
module sbs_hamm_enc #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CW     = DATA_W + CHK_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     cw_o
);

    always_comb begin
        logic [CW-1:0] w;
        logic          par;
        int            d;
        w = '0;
        d = 0;
        // data bits go to the non-power-of-two positions, ascending
        for (int j = 1; j < CW; j++) begin
            if ((j & (j - 1)) != 0) begin
                w[j] = data_i[d];
                d++;
            end
        end
        // check bit 2^i gives even parity over positions with bit i set
        for (int i = 0; i < CHK_W; i++) begin
            par = 1'b0;
            for (int j = 1; j < CW; j++) begin
                if (((j >> i) & 1) == 1) par = par ^ w[j];
            end
            w[1 << i] = par;
        end
        // position 0 completes even parity over the whole codeword
        w[0] = ^w[CW-1:1];
        cw_o = w;
    end

endmodule

// File: rtl/sbs_hamm_dec.sv
module sbs_hamm_dec #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CW     = DATA_W + CHK_W + 1
) (
    input  logic [CW-1:0]      cw_i,
    output logic [DATA_W-1:0]  data_o,
    output sbs_pkg::rd_kind_e  kind_o,
    output logic [CHK_W:0]     syn_o
);

    always_comb begin
        logic [CHK_W-1:0] s;
        logic             p;
        logic             fix;
        logic [CW-1:0]    w;
        logic [CW-1:0]    src;
        int               d;
        s = '0;
        for (int j = 1; j < CW; j++) begin
            if (cw_i[j]) s = s ^ CHK_W'(j);
        end
        p   = ^cw_i;
        fix = p && (int'(s) < CW);
        w   = cw_i;
        if (fix) begin
            for (int j = 0; j < CW; j++) begin
                if (CHK_W'(j) == s) w[j] = ~w[j];
            end
        end
        if (!p && s == '0)  kind_o = sbs_pkg::RD_CLEAN;
        else if (fix)       kind_o = sbs_pkg::RD_FIXED;
        else                kind_o = sbs_pkg::RD_BROKEN;
        // uncorrectable words pass their data bits through untouched
        src    = (kind_o == sbs_pkg::RD_BROKEN) ? cw_i : w;
        data_o = '0;
        d      = 0;
        for (int j = 1; j < CW; j++) begin
            if ((j & (j - 1)) != 0) begin
                data_o[d] = src[j];
                d++;
            end
        end
        syn_o = {p, s};
    end

endmodule

// File: rtl/sbs_col_steer.sv
module sbs_col_steer #(
    parameter int CW    = 22,
    parameter int NSP   = 2,
    parameter int POS_W = 5
) (
    input  logic [NSP-1:0]            map_v,
    input  logic [NSP-1:0][POS_W-1:0] map_pos,
    input  logic [CW-1:0]             wr_cw,
    output logic [CW+NSP-1:0]         wr_st,
    input  logic [CW+NSP-1:0]         rd_st,
    output logic [CW-1:0]             rd_cw
);

    logic [NSP-1:0] eff;

    // an entry counts only if in range and not shadowed by an earlier one
    always_comb begin
        for (int k = 0; k < NSP; k++) begin
            eff[k] = map_v[k] && (int'(map_pos[k]) < CW);
            for (int m = 0; m < k; m++) begin
                if (map_v[m] && map_pos[m] == map_pos[k]) eff[k] = 1'b0;
            end
        end
    end

    assign wr_st[CW-1:0] = wr_cw;

    for (genvar k = 0; k < NSP; k++) begin : g_spare
        assign wr_st[CW+k] = eff[k] ? wr_cw[map_pos[k]] : 1'b0;
    end

    always_comb begin
        rd_cw = rd_st[CW-1:0];
        for (int k = 0; k < NSP; k++) begin
            if (eff[k]) begin
                for (int i = 0; i < CW; i++) begin
                    if (map_pos[k] == POS_W'(i)) rd_cw[i] = rd_st[CW+k];
                end
            end
        end
    end

endmodule

// File: rtl/spare_steer_ecc.sv
module spare_steer_ecc #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int NSP    = 2,
    localparam int CHK_W = sbs_pkg::chk_bits(DATA_W),
    localparam int CW    = DATA_W + CHK_W + 1,
    localparam int ST_W  = CW + NSP,
    localparam int POS_W = $clog2(CW),
    localparam int SEL_W = (NSP > 1) ? $clog2(NSP) : 1,
    localparam int SYN_W = CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic [SYN_W-1:0]  syndrome,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_en,
    input  logic [POS_W-1:0]  cfg_pos,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ST_W-1:0]   mem_wdata,
    input  logic [ST_W-1:0]   mem_rdata
);

    typedef struct packed {
        logic [NSP-1:0]            mv;
        logic [NSP-1:0][POS_W-1:0] mp;
        logic                      rv;
        logic [DATA_W-1:0]         rdat;
        logic                      c;
        logic                      u;
        logic [SYN_W-1:0]          syn;
    } state_t;

    state_t st_d, st_q;

    logic [NSP-1:0]            map_v_now;
    logic [NSP-1:0][POS_W-1:0] map_p_now;
    logic [CW-1:0]             enc_cw;
    logic [CW-1:0]             rd_cw;
    logic [DATA_W-1:0]         dec_data;
    sbs_pkg::rd_kind_e         dec_kind;
    logic [SYN_W-1:0]          dec_syn;
    logic                      rd_go;

    // mapping seen by this cycle's access: a pending update already counts
    always_comb begin
        map_v_now = st_q.mv;
        map_p_now = st_q.mp;
        if (cfg_we) begin
            map_v_now[cfg_sel] = cfg_en;
            map_p_now[cfg_sel] = cfg_pos;
        end
    end

    assign rd_go    = rd_en && !wr_en;
    assign mem_we   = wr_en;
    assign mem_re   = rd_go;
    assign mem_addr = addr;

    sbs_hamm_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW(CW)) u_enc (
        .data_i (wr_data),
        .cw_o   (enc_cw)
    );

    sbs_col_steer #(.CW(CW), .NSP(NSP), .POS_W(POS_W)) u_steer (
        .map_v   (map_v_now),
        .map_pos (map_p_now),
        .wr_cw   (enc_cw),
        .wr_st   (mem_wdata),
        .rd_st   (mem_rdata),
        .rd_cw   (rd_cw)
    );

    sbs_hamm_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW(CW)) u_dec (
        .cw_i   (rd_cw),
        .data_o (dec_data),
        .kind_o (dec_kind),
        .syn_o  (dec_syn)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mv   = map_v_now;
        st_d.mp   = map_p_now;
        st_d.rv   = rd_go;
        st_d.rdat = rd_go ? dec_data : '0;
        st_d.c    = rd_go && (dec_kind == sbs_pkg::RD_FIXED);
        st_d.u    = rd_go && (dec_kind == sbs_pkg::RD_BROKEN);
        st_d.syn  = rd_go ? dec_syn : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid   = st_q.rv;
    assign rd_data    = st_q.rdat;
    assign err_corr   = st_q.c;
    assign err_uncorr = st_q.u;
    assign syndrome   = st_q.syn;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int SYN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_we,
    input logic             mem_re,
    input logic             rd_valid,
    input logic             err_corr,
    input logic             err_uncorr,
    input logic [SYN_W-1:0] syndrome
);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> rd_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !rd_valid);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_clean_syn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !err_corr && !err_uncorr) |-> (syndrome == '0));

    assert_corr_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_corr |-> syndrome[SYN_W-1]);

    assert_uncorr_syn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_uncorr |-> (syndrome != '0 && !syndrome[SYN_W-1]));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!err_corr && !err_uncorr && syndrome == '0));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_corr, err_uncorr}));

endmodule

bind spare_steer_ecc sbs_checker #(.SYN_W(SYN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .rd_valid   (rd_valid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .syndrome   (syndrome)
);

// File: tb/spare_steer_ecc_test.sv
`timescale 1ns/1ps
module spare_steer_ecc_test;

    localparam int DW  = 16;
    localparam int AW  = 4;
    localparam int CW  = 22;
    localparam int SW  = 24;
    localparam int PW  = 5;
    localparam int NWD = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wr_data;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          err_corr, err_uncorr;
    logic [5:0]    syndrome;
    logic          cfg_we;
    logic [0:0]    cfg_sel;
    logic          cfg_en;
    logic [PW-1:0] cfg_pos;
    logic          mem_we, mem_re;
    logic [AW-1:0] mem_addr;
    logic [SW-1:0] mem_wdata, mem_rdata;

    logic [SW-1:0] mem [NWD];
    logic [SW-1:0] flip;

    int n_chk  = 0;
    int n_fail = 0;

    // reference state
    logic [DW-1:0] gold [NWD];
    logic          mv [2];
    int            mp [2];

    always #4 clk = ~clk;

    spare_steer_ecc uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .syndrome(syndrome),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_pos(cfg_pos),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // array model: synchronous write, asynchronous read, injectable flips
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr] ^ flip;

    function automatic int dpos(int d);
        int c = 0;
        for (int j = 1; j < CW; j++) begin
            if ((j & (j - 1)) != 0) begin
                if (c == d) return j;
                c++;
            end
        end
        return -1;
    endfunction

    function automatic logic [DW-1:0] patt(int a, int s);
        return DW'((a * 4951 + s * 7919 + 3) ^ 16'hA5C3);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: predict from the driven inputs, then compare after the edge
    task automatic tick(string tag);
        logic          nv [2];
        int            np [2];
        logic          ev [2];
        logic          xv, xc, xu;
        logic [DW-1:0] xd, dfl;
        logic [5:0]    xs;
        logic          ok, par, e;
        logic [DW-1:0] got;
        int            n, sx;
        nv = mv; np = mp;
        if (cfg_we) begin
            nv[cfg_sel] = cfg_en;
            np[cfg_sel] = int'(cfg_pos);
        end
        ev[0] = nv[0] && np[0] < CW;
        ev[1] = nv[1] && np[1] < CW && !(nv[0] && np[0] == np[1]);
        #1;
        if (wr_en) begin
            // codeword layout
            ok  = mem_we && (mem_addr == addr) && !mem_re && ((^mem_wdata[CW-1:0]) == 1'b0);
            for (int i = 0; i < 5; i++) begin
                par = 1'b0;
                for (int j = 1; j < CW; j++) if (((j >> i) & 1) == 1) par ^= mem_wdata[j];
                if (par) ok = 1'b0;
            end
            for (int d = 0; d < DW; d++) got[d] = mem_wdata[dpos(d)];
            if (got != wr_data) ok = 1'b0;
            chk(ok, "R1", "codeword", 64'(mem_wdata), 64'(wr_data));
            // spare columns
            for (int k = 0; k < 2; k++) begin
                e = ev[k] ? mem_wdata[np[k]] : 1'b0;
                chk(mem_wdata[CW+k] == e, ev[k] ? "R8" : "R10", "spare bit",
                    64'(mem_wdata[CW+k]), 64'(e));
            end
        end
        xv = rd_en && !wr_en;
        xd = '0; xc = 0; xu = 0; xs = '0;
        if (xv) begin
            n = 0; sx = 0; dfl = '0;
            for (int i = 0; i < CW; i++) begin
                e = flip[i];
                for (int k = 0; k < 2; k++) if (ev[k] && np[k] == i) e = flip[CW+k];
                if (e) begin
                    n++;
                    sx ^= i;
                    for (int d = 0; d < DW; d++) if (dpos(d) == i) dfl[d] = 1'b1;
                end
            end
            xd = gold[addr] ^ ((n == 2) ? dfl : '0);
            xc = (n == 1);
            xu = (n == 2);
            xs = (n == 0) ? 6'd0 : (n == 1) ? {1'b1, 5'(sx)} : {1'b0, 5'(sx)};
        end
        @(posedge clk);
        mv = nv; mp = np;
        if (wr_en) gold[addr] = wr_data;
        @(negedge clk);
        chk({rd_valid, err_corr, err_uncorr, syndrome, rd_data} == {xv, xc, xu, xs, xd}, tag,
            "{valid,corr,uncorr,syn,data}",
            64'({rd_valid, err_corr, err_uncorr, syndrome, rd_data}),
            64'({xv, xc, xu, xs, xd}));
    endtask

    task automatic op(bit we, bit re, int a, logic [DW-1:0] d, string tag);
        wr_en = we; rd_en = re; addr = AW'(a); wr_data = d;
        tick(tag);
        wr_en = 0; rd_en = 0; cfg_we = 0;
    endtask

    task automatic fill(int seed, string tag);
        for (int a = 0; a < NWD; a++) op(1, 0, a, patt(a, seed), tag);
    endtask

    task automatic rd_flip(int a, logic [SW-1:0] f, string tag);
        flip = f;
        op(0, 1, a, '0, tag);
        flip = '0;
    endtask

    task automatic set_cfg(int sel, bit en, int pos);
        cfg_we = 1; cfg_sel = 1'(sel); cfg_en = en; cfg_pos = PW'(pos);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0;
        cfg_we = 0; cfg_sel = '0; cfg_en = 0; cfg_pos = '0; flip = '0;
        mv[0] = 0; mv[1] = 0; mp[0] = 0; mp[1] = 0;
        for (int a = 0; a < NWD; a++) gold[a] = '0;
        repeat (3) @(negedge clk);
        chk({rd_valid, err_corr, err_uncorr, syndrome} == 9'd0, "R6", "reset outputs",
            64'({rd_valid, err_corr, err_uncorr, syndrome}), 64'd0);
        rst_n = 1;

        fill(0, "R1");
        op(0, 1, 0, '0, "R3");
        op(0, 1, 5, '0, "R3");
        op(0, 1, 15, '0, "R3");
        // write wins over read in the same cycle
        op(1, 1, 2, 16'h1234, "R2");
        op(0, 1, 2, '0, "R2");
        // reset left steering off: a column fault is corrected, not masked (R7)
        rd_flip(4, SW'(1) << 3, "R7");
        // single errors at parity, check and data positions
        rd_flip(4, SW'(1) << 0, "R4");
        rd_flip(4, SW'(1) << 1, "R4");
        rd_flip(4, SW'(1) << 5, "R4");
        rd_flip(4, SW'(1) << 16, "R4");
        rd_flip(4, SW'(1) << 21, "R4");
        // double errors
        rd_flip(7, (SW'(1) << 0) | (SW'(1) << 5), "R5");
        rd_flip(7, (SW'(1) << 3) | (SW'(1) << 5), "R5");
        rd_flip(7, (SW'(1) << 9) | (SW'(1) << 20), "R5");

        // steer column 7 with a write in the same cycle (new mapping applies)
        set_cfg(0, 1, 7);
        op(1, 0, 3, 16'hBEEF, "R7");
        fill(1, "R8");
        for (int a = 0; a < 4; a++) rd_flip(a, SW'(1) << 7, "R9");
        rd_flip(6, (SW'(1) << 7) | (SW'(1) << 3), "R9");
        rd_flip(9, SW'(1) << CW, "R9");

        // duplicate column on entry 1
        set_cfg(1, 1, 7);
        op(0, 0, 0, '0, "R10");
        fill(2, "R10");
        rd_flip(1, (SW'(1) << (CW + 1)) | (SW'(1) << 7), "R10");

        // out-of-range column on entry 1
        set_cfg(1, 1, 30);
        op(0, 0, 0, '0, "R11");
        fill(3, "R11");
        rd_flip(5, SW'(1) << (CW + 1), "R11");
        rd_flip(5, SW'(1) << 21, "R11");

        // two distinct steered columns
        set_cfg(1, 1, 12);
        op(0, 0, 0, '0, "R8");
        fill(4, "R8");
        rd_flip(8, (SW'(1) << 7) | (SW'(1) << 12), "R9");
        rd_flip(11, (SW'(1) << (CW + 1)) | (SW'(1) << 7), "R9");

        // disable entry 0
        set_cfg(0, 0, 7);
        op(0, 0, 0, '0, "R12");
        fill(5, "R12");
        rd_flip(10, SW'(1) << 7, "R12");
        rd_flip(10, SW'(1) << CW, "R12");
        rd_flip(13, SW'(1) << 12, "R12");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule